// File: doc/BRIEF.md
# Flash Identification Probe Sequencer

This block runs the identification step for a serial NOR flash attached to a controller, right after reset, when the flash may already have been left in a dual-line or quad-line command mode by non-volatile settings or an earlier boot stage. It asks a lower-level serial shifter for the device identity over one line first. A response with three leading bytes that are all ones or all zeros means the device did not understand the single-line command. In that case the block moves every command class to the wide protocol picked by a configuration input and asks again with the multi-line identify opcode.

The block drives a request/acknowledge port toward the shifter. It reports the identity bytes, the protocol for each of the four command classes (register access, read, write, erase), and end-of-probe and failure flags. Matching the identity against a device list and the bit-level shifting are done elsewhere.

Protocol codes used on every protocol port and on the mode input: 0 = one line for command, address and data (1-1-1), 1 = two lines for all phases (2-2-2), 2 = four lines for all phases (4-4-4). A mode value of 3 is treated as 0. Identity byte k (first received byte is k = 0) sits at bits [8k+7:8k] of both the transfer data input and the identity output.

Top module: `flash_id_probe`

## Requirements
- R1: After reset, no transfer is requested, all four class protocols are 0, the identity is all zero, and the done and error flags are low.
- R2: An accepted start sets all four class protocols to 0 and, in the next cycle, requests a transfer with opcode 0x9F, length ID_BYTES and protocol 0.
- R3: A requested transfer keeps its request, opcode, length and protocol unchanged until the cycle in which it is acknowledged.
- R4: A first response counts as invalid only when bytes 0, 1 and 2 are all 0xFF or all 0x00; a valid first response ends the probe with the identity equal to the whole response and all class protocols at 0.
- R5: The mode input is captured when a start is accepted; an invalid first response with captured mode 2 sets all four class protocols to 2 and requests a retry with opcode 0xAF, length 3 and protocol 2.
- R6: An invalid first response with captured mode 1 sets all four class protocols to 1 and requests the 0xAF retry with length 3 and protocol 1.
- R7: When the retry succeeds, identity bytes 0 to 2 take the retry response and every byte from 3 upward reads zero.
- R8: An invalid first response with captured mode 0 or 3 makes no retry; the probe ends with the invalid identity reported and all class protocols at 0.
- R9: An acknowledge with the error input high on either transfer ends the probe with the error flag high, issues no further request, and the error flag stays high until the next accepted start.
- R10: The done flag is high for exactly one cycle at the end of each probe, successful or failed.
- R11: A start while a probe is running is ignored: the pending request, opcode and class protocols are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a probe (accepted only when idle) |
| mode_i | input | 2 | Wide protocol to fall back to: 0 none, 1 dual, 2 quad |
| xfer_req_o | output | 1 | Transfer request to the shifter |
| xfer_opcode_o | output | 8 | Opcode of the requested transfer |
| xfer_len_o | output | LEN_W | Number of response bytes to read |
| xfer_proto_o | output | 2 | Protocol code for the requested transfer |
| xfer_ack_i | input | 1 | Transfer finished; data and error valid |
| xfer_err_i | input | 1 | Transfer failed (valid with ack) |
| xfer_data_i | input | 8*ID_BYTES | Response bytes, byte 0 lowest |
| id_o | output | 8*ID_BYTES | Identity bytes, byte 0 lowest |
| proto_reg_o | output | 2 | Protocol for register-access commands |
| proto_read_o | output | 2 | Protocol for read commands |
| proto_write_o | output | 2 | Protocol for write commands |
| proto_erase_o | output | 2 | Protocol for erase commands |
| busy_o | output | 1 | Probe in progress |
| done_o | output | 1 | One-cycle pulse at probe end |
| error_o | output | 1 | Last probe failed on a transfer error |

## Verification
The bench builds the block with its default ID_BYTES = 6, so the first request asks for six bytes and three identity bytes lie above the short retry; that makes the clearing of bytes 3 to 5 observable, since the bench puts random filler on those lanes during the retry. With six bytes the bench can also place all-ones or all-zeros patterns only in the first three bytes, or break them in just one byte, to probe the edge of the validity test.

// File: rtl/flash_probe_pkg.sv
package flash_probe_pkg;
  localparam logic [1:0] LINES_1 = 2'd0;
  localparam logic [1:0] LINES_2 = 2'd1;
  localparam logic [1:0] LINES_4 = 2'd2;
  localparam logic [7:0] OP_ID_STD  = 8'h9F;
  localparam logic [7:0] OP_ID_WIDE = 8'hAF;
  localparam int NUM_CLASSES = 4;
  localparam int SHORT_ID_BYTES = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_STD, ST_WIDE} probe_state_e;

  function automatic logic [1:0] wide_of_mode(input logic [1:0] m);
    case (m)
      2'd1:    return LINES_2;
      2'd2:    return LINES_4;
      default: return LINES_1;
    endcase
  endfunction
endpackage

// File: rtl/id_blank_detect.sv
module id_blank_detect
  import flash_probe_pkg::*;
(
  input  logic [8*SHORT_ID_BYTES-1:0] head_i,
  output logic                        blank_o
);
  logic all_ones, all_zeros;
  always_comb begin
    all_ones  = 1'b1;
    all_zeros = 1'b1;
    for (int k = 0; k < SHORT_ID_BYTES; k++) begin
      all_ones  &= (head_i[8*k +: 8] == 8'hFF);
      all_zeros &= (head_i[8*k +: 8] == 8'h00);
    end
    blank_o = all_ones | all_zeros;
  end
endmodule

// File: rtl/proto_bank.sv
module proto_bank
  import flash_probe_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clear_i,
  input  logic                       load_i,
  input  logic [1:0]                 proto_i,
  output logic [2*NUM_CLASSES-1:0]   proto_o
);
  for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_class
    logic [1:0] cls_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cls_q <= LINES_1;
      else if (clear_i) cls_q <= LINES_1;
      else if (load_i)  cls_q <= proto_i;
    end
    assign proto_o[2*g +: 2] = cls_q;

    assert_clear_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_i |=> (cls_q == LINES_1));
  end
endmodule

// File: rtl/id_store.sv
module id_store
  import flash_probe_pkg::*;
#(
  parameter int ID_BYTES = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cap_full_i,
  input  logic                  cap_short_i,
  input  logic [8*ID_BYTES-1:0] data_i,
  output logic [8*ID_BYTES-1:0] id_o
);
  for (genvar k = 0; k < ID_BYTES; k++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          byte_q <= 8'h00;
      else if (cap_full_i)  byte_q <= data_i[8*k +: 8];
      else if (cap_short_i) byte_q <= (k < SHORT_ID_BYTES) ? data_i[8*k +: 8] : 8'h00;
    end
    assign id_o[8*k +: 8] = byte_q;
  end
endmodule

// File: rtl/flash_probe_fsm.sv
module flash_probe_fsm
  import flash_probe_pkg::*;
#(
  parameter int ID_BYTES = 6,
  parameter int LEN_W    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic             xfer_ack_i,
  input  logic             xfer_err_i,
  input  logic             blank_i,
  output logic             xfer_req_o,
  output logic [7:0]       xfer_opcode_o,
  output logic [LEN_W-1:0] xfer_len_o,
  output logic             clear_o,
  output logic             load_wide_o,
  output logic [1:0]       wide_proto_o,
  output logic             cap_full_o,
  output logic             cap_short_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             error_o
);
  probe_state_e state_q, state_d;
  logic [1:0]   wide_q;
  logic         done_q, error_q;
  logic         accept, fin_ok, fin_err;

  assign accept       = (state_q == ST_IDLE) && start_i;
  assign wide_proto_o = wide_q;

  always_comb begin
    state_d     = state_q;
    load_wide_o = 1'b0;
    cap_full_o  = 1'b0;
    cap_short_o = 1'b0;
    fin_ok      = 1'b0;
    fin_err     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_STD;
      ST_STD: if (xfer_ack_i) begin
        if (xfer_err_i) fin_err = 1'b1;
        else begin
          cap_full_o = 1'b1;
          if (blank_i && wide_q != LINES_1) begin
            load_wide_o = 1'b1;
            state_d     = ST_WIDE;
          end else fin_ok = 1'b1;
        end
      end
      ST_WIDE: if (xfer_ack_i) begin
        if (xfer_err_i) fin_err = 1'b1;
        else begin
          cap_short_o = 1'b1;
          fin_ok      = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (fin_ok || fin_err) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wide_q  <= LINES_1;
      done_q  <= 1'b0;
      error_q <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin_ok | fin_err;
      if (accept) begin
        wide_q  <= wide_of_mode(mode_i);
        error_q <= 1'b0;
      end else if (fin_err) error_q <= 1'b1;
    end
  end

  assign clear_o       = accept;
  assign xfer_req_o    = (state_q == ST_STD) || (state_q == ST_WIDE);
  assign xfer_opcode_o = (state_q == ST_WIDE) ? OP_ID_WIDE :
                         (state_q == ST_STD)  ? OP_ID_STD  : 8'h00;
  assign xfer_len_o    = (state_q == ST_WIDE) ? LEN_W'(SHORT_ID_BYTES) :
                         (state_q == ST_STD)  ? LEN_W'(ID_BYTES) : '0;
  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = done_q;
  assign error_o       = error_q;

  assert_req_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_req_o && !xfer_ack_i) |=> (xfer_req_o && $stable(xfer_opcode_o) && $stable(xfer_len_o)));
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_err_ends_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_req_o && xfer_ack_i && xfer_err_i) |=> (error_o && done_o && !xfer_req_o));
  assert_start_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !xfer_ack_i) |=> (busy_o && $stable(xfer_opcode_o)));
endmodule

// File: rtl/flash_id_probe.sv
module flash_id_probe
  import flash_probe_pkg::*;
#(
  parameter int ID_BYTES = 6,
  localparam int ID_W    = 8 * ID_BYTES,
  localparam int LEN_W   = $clog2(ID_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  output logic             xfer_req_o,
  output logic [7:0]       xfer_opcode_o,
  output logic [LEN_W-1:0] xfer_len_o,
  output logic [1:0]       xfer_proto_o,
  input  logic             xfer_ack_i,
  input  logic             xfer_err_i,
  input  logic [ID_W-1:0]  xfer_data_i,
  output logic [ID_W-1:0]  id_o,
  output logic [1:0]       proto_reg_o,
  output logic [1:0]       proto_read_o,
  output logic [1:0]       proto_write_o,
  output logic [1:0]       proto_erase_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             error_o
);
  logic                     blank, clear, load_wide, cap_full, cap_short;
  logic [1:0]               wide_proto;
  logic [2*NUM_CLASSES-1:0] protos;

  id_blank_detect u_blank (
    .head_i  (xfer_data_i[8*SHORT_ID_BYTES-1:0]),
    .blank_o (blank)
  );

  flash_probe_fsm #(.ID_BYTES(ID_BYTES), .LEN_W(LEN_W)) u_fsm (
    .clk_i, .rst_ni, .start_i, .mode_i, .xfer_ack_i, .xfer_err_i,
    .blank_i       (blank),
    .xfer_req_o, .xfer_opcode_o, .xfer_len_o,
    .clear_o       (clear),
    .load_wide_o   (load_wide),
    .wide_proto_o  (wide_proto),
    .cap_full_o    (cap_full),
    .cap_short_o   (cap_short),
    .busy_o, .done_o, .error_o
  );

  proto_bank u_protos (
    .clk_i, .rst_ni,
    .clear_i (clear),
    .load_i  (load_wide),
    .proto_i (wide_proto),
    .proto_o (protos)
  );

  id_store #(.ID_BYTES(ID_BYTES)) u_id (
    .clk_i, .rst_ni,
    .cap_full_i  (cap_full),
    .cap_short_i (cap_short),
    .data_i      (xfer_data_i),
    .id_o
  );

  // class order: register, read, write, erase
  assign proto_reg_o   = protos[1:0];
  assign proto_read_o  = protos[3:2];
  assign proto_write_o = protos[5:4];
  assign proto_erase_o = protos[7:6];
  assign xfer_proto_o  = proto_reg_o;

  assert_wide_retry_proto_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_req_o && xfer_opcode_o == OP_ID_WIDE) |-> (xfer_proto_o != LINES_1));
  assert_classes_agree_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (proto_reg_o == proto_read_o) && (proto_reg_o == proto_write_o) && (proto_reg_o == proto_erase_o));
  if (ID_BYTES > SHORT_ID_BYTES) begin : g_upper_chk
    assert_upper_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !error_o && proto_reg_o != LINES_1) |-> (id_o[ID_W-1:8*SHORT_ID_BYTES] == '0));
  end
endmodule

// File: tb/flash_id_probe_tb.sv
module flash_id_probe_tb;
  localparam int NB   = 6;
  localparam int W    = 8 * NB;
  localparam int LW   = $clog2(NB + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode = 2'd0;
  logic xfer_req, ack = 1'b0, err = 1'b0;
  logic [7:0] opcode;
  logic [LW-1:0] len;
  logic [1:0] xproto, p_reg, p_rd, p_wr, p_er;
  logic [W-1:0] data = '0, id;
  logic busy, done, error;

  int checks = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;

  flash_id_probe #(.ID_BYTES(NB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .xfer_req_o(xfer_req), .xfer_opcode_o(opcode), .xfer_len_o(len), .xfer_proto_o(xproto),
    .xfer_ack_i(ack), .xfer_err_i(err), .xfer_data_i(data), .id_o(id),
    .proto_reg_o(p_reg), .proto_read_o(p_rd), .proto_write_o(p_wr), .proto_erase_o(p_er),
    .busy_o(busy), .done_o(done), .error_o(error)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: act=%0d exp<150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic is_blank(input logic [W-1:0] r);
    return (r[23:0] == 24'hFFFFFF) || (r[23:0] == 24'h000000);
  endfunction

  function automatic logic [1:0] wide_for(input logic [1:0] m);
    return (m == 2'd1) ? 2'd1 : (m == 2'd2) ? 2'd2 : 2'd0;
  endfunction

  function automatic logic [7:0] all_protos(input logic [1:0] p);
    return {p, p, p, p};
  endfunction

  function automatic logic [W-1:0] rnd_word();
    return {$urandom, $urandom};
  endfunction

  // wait d cycles while request pending; optionally poke start (R11)
  task automatic hold_req(input int d, input logic [7:0] op, input logic [1:0] pr, input string tag);
    for (int i = 0; i < d; i++) begin
      if (i == 0 && ($urandom % 2) == 1) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk({tag, " held req"}, {xfer_req, opcode}, {1'b1, op});
      chk("R11 protos unchanged while busy", {56'd0, all_protos(p_reg)} | {p_rd, p_wr, p_er, 2'b0} & 64'h0 | {56'd0, p_er, p_wr, p_rd, p_reg},
          {56'd0, all_protos(pr)});
    end
  endtask

  task automatic probe(input logic [1:0] m, input logic [W-1:0] r1, input logic e1,
                       input logic [W-1:0] r2, input logic e2);
    logic [1:0] wp;
    logic retry;
    wp = wide_for(m);
    retry = !e1 && is_blank(r1) && (wp != 2'd0);
    start = 1'b1; mode = m;
    @(negedge clk);
    start = 1'b0; mode = 2'($urandom);
    chk("R2 first request", {xfer_req, opcode, 4'(len), xproto}, {1'b1, 8'h9F, 4'(NB), 2'd0});
    chk("R2 classes single", {56'd0, p_er, p_wr, p_rd, p_reg}, 64'd0);
    hold_req($urandom % 4, 8'h9F, 2'd0, "R3");
    ack = 1'b1; err = e1; data = r1;
    @(negedge clk);
    ack = 1'b0; err = 1'b0; data = rnd_word();
    if (e1) begin
      chk("R9 error end", {xfer_req, done, error}, {1'b0, 1'b1, 1'b1});
    end else if (retry) begin
      chk(m == 2'd2 ? "R5 retry request" : "R6 retry request",
          {done, xfer_req, opcode, 4'(len), xproto}, {1'b0, 1'b1, 8'hAF, 4'd3, wp});
      chk(m == 2'd2 ? "R5 classes wide" : "R6 classes wide",
          {56'd0, p_er, p_wr, p_rd, p_reg}, {56'd0, all_protos(wp)});
      hold_req($urandom % 4, 8'hAF, wp, "R3 retry");
      ack = 1'b1; err = e2; data = r2;
      @(negedge clk);
      ack = 1'b0; err = 1'b0; data = rnd_word();
      if (e2) chk("R9 retry error", {xfer_req, done, error}, {1'b0, 1'b1, 1'b1});
      else begin
        chk("R10 done after retry", {xfer_req, done, error}, {1'b0, 1'b1, 1'b0});
        chk("R7 short identity", 64'(id), 64'(r2[23:0]));
      end
    end else begin
      chk("R10 done after first", {xfer_req, done, error}, {1'b0, 1'b1, 1'b0});
      chk(is_blank(r1) ? "R8 no retry identity" : "R4 identity", 64'(id), 64'(r1));
      chk(is_blank(r1) ? "R8 classes single" : "R4 classes single",
          {56'd0, p_er, p_wr, p_rd, p_reg}, 64'd0);
    end
    @(negedge clk);
    chk("R10 done one cycle", {done, busy, xfer_req}, 3'b000);
    if (e1 || (retry && e2)) chk("R9 error sticky", 64'(error), 64'd1);
  endtask

  initial begin
    logic [W-1:0] r;
    void'($urandom(32'd20240611));
    @(negedge clk); @(negedge clk);
    chk("R1 reset outputs", {xfer_req, done, error, busy, p_er, p_wr, p_rd, p_reg}, 64'd0);
    chk("R1 reset identity", 64'(id), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    probe(2'd0, 48'h0000_0012_20C2, 1'b0, '0, 1'b0);                 // R4 valid
    probe(2'd2, 48'hA5A5_A5FF_FFFF, 1'b0, 48'h7777_7718_BA20, 1'b0); // R5 quad
    probe(2'd1, 48'h1234_5600_0000, 1'b0, 48'hDEAD_BE16_BB20, 1'b0); // R6 dual
    probe(2'd0, 48'h0000_0000_0000, 1'b0, '0, 1'b0);                 // R8
    probe(2'd3, 48'hFFFF_FFFF_FFFF, 1'b0, '0, 1'b0);                 // R8 mode 3
    probe(2'd2, 48'h0000_00FE_FFFF, 1'b0, '0, 1'b0);                 // R4 near-blank
    probe(2'd1, 48'h0000_0001_0000, 1'b0, '0, 1'b0);                 // R4 near-blank
    probe(2'd2, 48'h0000_00FF_00FF, 1'b0, '0, 1'b0);                 // R4 mixed
    probe(2'd2, 48'hFFFF_FFFF_FFFF, 1'b1, '0, 1'b0);                 // R9 first error
    probe(2'd2, 48'hFFFF_FFFF_FFFF, 1'b0, 48'h1111_1118_BA20, 1'b1); // R9 retry error
    // R9: error clears on next start
    start = 1'b1; mode = 2'd0;
    @(negedge clk);
    start = 1'b0;
    chk("R9 error cleared by start", 64'(error), 64'd0);
    ack = 1'b1; data = 48'h0000_0001_0203;
    @(negedge clk);
    ack = 1'b0;
    @(negedge clk);

    // random probes
    for (int n = 0; n < 60; n++) begin
      int kind;
      kind = $urandom % 3;
      r = rnd_word();
      if (kind == 0) r[23:0] = 24'hFFFFFF;
      else if (kind == 1) r[23:0] = 24'h000000;
      else if (is_blank(r)) r[0] = ~r[0];
      probe(2'($urandom), r, ($urandom % 8) == 0, rnd_word(), ($urandom % 8) == 0);
      for (int g = 0; g < int'($urandom % 3); g++) @(negedge clk);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule